// File: doc/BRIEF.md
# DDR2 Read Burst Data Sequencer

This block lives on the controller side of a double-data-rate SDRAM interface. It predicts, clock by clock, which read data beats the memory will place on the data bus. Each accepted read command brings an identifying tag, a bank, a start column and an auto-precharge flag. The programmed CAS latency, additive latency and burst length set the schedule. The data of a read starts a read latency (additive plus CAS latency) after the command. It then runs at two beats per clock: two clocks for a four-beat burst and four clocks for an eight-beat burst.

The schedule is kept as a line of future clock slots. Each command writes its beats into the slots where they will appear, and the line shifts by one slot per clock. A newer read overwrites whatever an older read left in the same slots. This produces gapless chaining of bursts issued at the burst spacing. It also truncates an eight-beat burst to its first four beats when a second read follows exactly two clocks after it. Read data capture logic uses the registered output stream to label incoming data with its command and position.

Top module: `rsq_read_seq`

## Requirements
- R1: While reset is high, and on the first clock after reset is sampled, `out_valid` is 0; reset discards every pending scheduled beat.
- R2: The first beat pair of a read accepted at clock edge k appears on the outputs after edge k+CL+AL, with `out_beat` = 0. CL must be at least 2.
- R3: Beats come two per clock in ascending order. `out_beat` holds the index of the earlier beat of the pair: 0 then 2 for a four-beat burst (`cfg_bl8` = 0), and 0, 2, 4, 6 for an eight-beat burst (`cfg_bl8` = 1). `out_last` is 1 only on the clock that holds the final pair of a burst.
- R4: Reads issued every 2 clocks with four-beat bursts, or every 4 clocks with eight-beat bursts, give a data stream with no idle clock between bursts.
- R5: An eight-beat read followed 2 clocks later by another read delivers only its pairs 0 and 2. The newer burst then follows from beat 0 on the next clock.
- R6: `out_valid` is 0 on every clock with no scheduled beat.
- R7: Every valid output clock carries the tag, bank and column of the read that owns the beat, whether the two reads target the same bank or different banks.
- R8: When `rd_valid` is 0, the command fields and any configuration change schedule nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cas_lat | input | CL_W | CAS latency in clocks (at least 2) |
| cfg_add_lat | input | AL_W | Additive latency in clocks |
| cfg_bl8 | input | 1 | 1: eight-beat bursts, 0: four-beat bursts |
| rd_valid | input | 1 | A read command is presented this clock |
| rd_tag | input | 4 | Identifier of the read command |
| rd_bank | input | 3 | Bank of the read |
| rd_col | input | 10 | Start column of the read |
| rd_ap | input | 1 | Read carries auto-precharge |
| out_valid | output | 1 | A beat pair is expected on the bus this clock |
| out_last | output | 1 | This pair is the final one of its burst |
| out_beat | output | 3 | Index of the earlier beat of the pair |
| out_tag | output | 4 | Tag of the owning read |
| out_bank | output | 3 | Bank of the owning read |
| out_col | output | 10 | Start column of the owning read |

## Verification
The assertions rely on a few assumptions about the command stream. Reads come at least two clocks apart. No read arrives three clocks after an eight-beat read. An eight-beat read with auto-precharge is never cut by a read two clocks later. The latency and burst-length settings hold steady while any beat is still pending. The random stimulus respects all of this: it picks burst gaps only from the legal sets, it forces a wide gap after an auto-precharge eight-beat read, and it drains the schedule before it changes the configuration. Configuration is toggled freely only in the window that exercises ignored inputs.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  localparam int unsigned RSQ_TAG_W  = 4;
  localparam int unsigned RSQ_BANK_W = 3;
  localparam int unsigned RSQ_COL_W  = 10;

  // one future clock of the expected data bus
  typedef struct packed {
    logic                  vld;
    logic                  last;
    logic [2:0]            beat;
    logic [RSQ_TAG_W-1:0]  tag;
    logic [RSQ_BANK_W-1:0] bank;
    logic [RSQ_COL_W-1:0]  col;
  } rsq_slot_t;

endpackage

// File: rtl/rsq_lat_calc.sv
module rsq_lat_calc #(
  parameter int unsigned CL_W = 3,
  parameter int unsigned AL_W = 3,
  parameter int unsigned RL_W = 4
) (
  input  logic [CL_W-1:0] cas_lat,
  input  logic [AL_W-1:0] add_lat,
  input  logic            bl8,
  output logic [RL_W-1:0] rd_lat,
  output logic [2:0]      burst_clks
);

  always_comb begin
    rd_lat     = RL_W'(cas_lat) + RL_W'(add_lat);
    burst_clks = bl8 ? 3'd4 : 3'd2;
  end

endmodule

// File: rtl/rsq_slot_line.sv
module rsq_slot_line
  import rsq_pkg::*;
#(
  parameter int unsigned DEPTH = 17,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [IDX_W-1:0] load_lo,
  input  logic [2:0]       load_n,
  input  rsq_slot_t        load_data,
  output rsq_slot_t        head
);

  rsq_slot_t slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rsq_slot_t shifted;
    rsq_slot_t fresh;
    int        offs;
    logic      hit;

    if (i == DEPTH - 1) begin : g_end
      assign shifted = '0;
    end else begin : g_mid
      assign shifted = slot_q[i+1];
    end

    always_comb begin
      offs       = i - int'(load_lo);
      hit        = load && (offs >= 0) && (offs < int'(load_n));
      fresh      = load_data;
      fresh.vld  = 1'b1;
      fresh.beat = 3'(2 * offs);
      fresh.last = (offs == int'(load_n) - 1);
    end

    // newer read wins any slot it covers: this is the truncation point
    always_ff @(posedge clk) begin
      if (rst)      slot_q[i] <= '0;
      else if (hit) slot_q[i] <= fresh;
      else          slot_q[i] <= shifted;
    end
  end

  assign head = slot_q[0];

  AST_LOAD_FITS: assert property (@(posedge clk) disable iff (rst)
    load |-> (int'(load_lo) + int'(load_n) <= int'(DEPTH)));  // R2

endmodule

// File: rtl/rsq_read_seq.sv
module rsq_read_seq
  import rsq_pkg::*;
#(
  parameter int unsigned CL_W = 3,
  parameter int unsigned AL_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CL_W-1:0]       cfg_cas_lat,
  input  logic [AL_W-1:0]       cfg_add_lat,
  input  logic                  cfg_bl8,
  input  logic                  rd_valid,
  input  logic [RSQ_TAG_W-1:0]  rd_tag,
  input  logic [RSQ_BANK_W-1:0] rd_bank,
  input  logic [RSQ_COL_W-1:0]  rd_col,
  input  logic                  rd_ap,
  output logic                  out_valid,
  output logic                  out_last,
  output logic [2:0]            out_beat,
  output logic [RSQ_TAG_W-1:0]  out_tag,
  output logic [RSQ_BANK_W-1:0] out_bank,
  output logic [RSQ_COL_W-1:0]  out_col
);

  localparam int unsigned RL_W   = ((CL_W > AL_W) ? CL_W : AL_W) + 1;
  localparam int unsigned MAX_RL = ((1 << CL_W) - 1) + ((1 << AL_W) - 1);
  localparam int unsigned DEPTH  = MAX_RL + 3;
  localparam int unsigned IDX_W  = $clog2(DEPTH);

  logic [RL_W-1:0]  rd_lat;
  logic [2:0]       burst_clks;
  logic [IDX_W-1:0] load_lo;
  rsq_slot_t        cmd_data;
  rsq_slot_t        head;
  rsq_slot_t        out_q;

  rsq_lat_calc #(.CL_W(CL_W), .AL_W(AL_W), .RL_W(RL_W)) u_lat (
    .cas_lat    (cfg_cas_lat),
    .add_lat    (cfg_add_lat),
    .bl8        (cfg_bl8),
    .rd_lat     (rd_lat),
    .burst_clks (burst_clks)
  );

  // the output register adds one clock, so the first pair lands at RL-1
  assign load_lo = IDX_W'(rd_lat - RL_W'(1));

  always_comb begin
    cmd_data      = '0;
    cmd_data.tag  = rd_tag;
    cmd_data.bank = rd_bank;
    cmd_data.col  = rd_col;
  end

  rsq_slot_line #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_line (
    .clk       (clk),
    .rst       (rst),
    .load      (rd_valid),
    .load_lo   (load_lo),
    .load_n    (burst_clks),
    .load_data (cmd_data),
    .head      (head)
  );

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= head;
  end

  assign out_valid = out_q.vld;
  assign out_last  = out_q.last;
  assign out_beat  = out_q.beat;
  assign out_tag   = out_q.tag;
  assign out_bank  = out_q.bank;
  assign out_col   = out_q.col;

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);  // R1
  AST_CL_MIN: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (cfg_cas_lat >= CL_W'(2)));  // R2
  AST_BEAT_EVEN: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_beat[0] == 1'b0));  // R3
  AST_LAST_POS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> (out_beat == 3'd2 || out_beat == 3'd6));  // R3
  AST_BURST_ORDER: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_beat != 3'd0) |->
      ($past(out_valid) && $past(out_tag) == out_tag &&
       $past(out_bank) == out_bank && $past(out_beat) + 3'd2 == out_beat));  // R3
  AST_CMD_SPACING: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);  // R4
  AST_CUT_AT_TWO: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_valid, 3) && $past(cfg_bl8, 3)) |-> !rd_valid);  // R5
  AST_AP_NOT_CUT: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_valid, 2) && $past(rd_ap, 2) && $past(cfg_bl8, 2)) |-> !rd_valid);  // R5

endmodule

// File: tb/rsq_read_seq_tb.sv
`timescale 1ns/1ps
module rsq_read_seq_tb;
  import rsq_pkg::*;

  localparam int N = 4096;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                  rst = 1'b1;
  logic [2:0]            cfg_cas_lat = 3'd3;
  logic [2:0]            cfg_add_lat = 3'd0;
  logic                  cfg_bl8 = 1'b0;
  logic                  rd_valid = 1'b0;
  logic [RSQ_TAG_W-1:0]  rd_tag = '0;
  logic [RSQ_BANK_W-1:0] rd_bank = '0;
  logic [RSQ_COL_W-1:0]  rd_col = '0;
  logic                  rd_ap = 1'b0;
  logic                  out_valid, out_last;
  logic [2:0]            out_beat;
  logic [RSQ_TAG_W-1:0]  out_tag;
  logic [RSQ_BANK_W-1:0] out_bank;
  logic [RSQ_COL_W-1:0]  out_col;

  rsq_read_seq u_dut (
    .clk(clk), .rst(rst), .cfg_cas_lat(cfg_cas_lat), .cfg_add_lat(cfg_add_lat),
    .cfg_bl8(cfg_bl8), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_bank(rd_bank),
    .rd_col(rd_col), .rd_ap(rd_ap), .out_valid(out_valid), .out_last(out_last),
    .out_beat(out_beat), .out_tag(out_tag), .out_bank(out_bank), .out_col(out_col)
  );

  int nchk = 0;
  int nfail = 0;
  int edge_n = 0;
  int idle_lbl = 1;   // R1 during reset, R6 normally, R8 in the ignored-input window

  bit                    ev    [N];
  logic [2:0]            ebeat [N];
  bit                    elast [N];
  logic [RSQ_TAG_W-1:0]  etag  [N];
  logic [RSQ_BANK_W-1:0] ebank [N];
  logic [RSQ_COL_W-1:0]  ecol  [N];
  int                    ereq  [N];

  function automatic int rl_of(int c, int a);  // R2: latency = CL + AL
    return c + a;
  endfunction

  function automatic int clks_of(bit b8);      // R3: two beats per clock
    return b8 ? 4 : 2;
  endfunction

  task automatic check();
    int e = edge_n;
    int lbl;
    if (e >= N) return;
    lbl = ev[e] ? ereq[e] : idle_lbl;
    nchk++;
    if (out_valid !== ev[e] ||
        (ev[e] && (out_beat !== ebeat[e] || out_last !== elast[e]))) begin
      nfail++;
      $display("FAIL R%0d edge %0d: valid/beat/last = %b/%0d/%b expected %b/%0d/%b",
               lbl, e, out_valid, out_beat, out_last, ev[e], ebeat[e], elast[e]);
    end
    if (ev[e]) begin
      nchk++;  // R7: owner fields
      if (out_tag !== etag[e] || out_bank !== ebank[e] || out_col !== ecol[e]) begin
        nfail++;
        $display("FAIL R7 edge %0d: tag/bank/col = %0d/%0d/%0d expected %0d/%0d/%0d",
                 e, out_tag, out_bank, out_col, etag[e], ebank[e], ecol[e]);
      end
    end
  endtask

  task automatic step();
    @(posedge clk);
    edge_n++;
    @(negedge clk);
    check();
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      rd_tag  = RSQ_TAG_W'($urandom);
      rd_bank = RSQ_BANK_W'($urandom);
      rd_col  = RSQ_COL_W'($urandom);
      rd_ap   = 1'($urandom);
      step();
    end
  endtask

  task automatic setcfg(int c, int a, bit b8);
    cfg_cas_lat = 3'(c);
    cfg_add_lat = 3'(a);
    cfg_bl8     = b8;
  endtask

  task automatic issue(int tag, int bank, int col, bit ap);
    int e = edge_n + 1;
    int r = rl_of(int'(cfg_cas_lat), int'(cfg_add_lat));
    int n = clks_of(cfg_bl8);
    rd_valid = 1'b1;
    rd_tag   = RSQ_TAG_W'(tag);
    rd_bank  = RSQ_BANK_W'(bank);
    rd_col   = RSQ_COL_W'(col);
    rd_ap    = ap;
    for (int j = 0; j < n; j++) begin
      int i = e + r + j;
      if (i < N) begin
        if (ev[i])                 ereq[i] = 5;  // R5: newer read takes over
        else if (j == 0 && ev[i-1]) ereq[i] = 4; // R4: joins the previous burst
        else if (j == 0)           ereq[i] = 2;  // R2: burst start
        else                       ereq[i] = 3;  // R3: later pair
        ev[i] = 1'b1; ebeat[i] = 3'(2 * j); elast[i] = (j == n - 1);
        etag[i] = RSQ_TAG_W'(tag); ebank[i] = RSQ_BANK_W'(bank); ecol[i] = RSQ_COL_W'(col);
      end
    end
    step();
    rd_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    nfail++; nchk++;
    $display("FAIL watchdog expired at edge %0d", edge_n);
    finish_run();
  end

  initial begin
    int tag = 0;
    void'($urandom(32'h5EED));
    for (int i = 0; i < N; i++) ev[i] = 1'b0;
    // R1: reset state
    @(negedge clk);
    step(); step(); step();
    rst = 1'b0;
    idle_lbl = 6;  // R6 from here on
    idle(2);

    // R4: four-beat reads every 2 clocks, RL = 5
    setcfg(3, 2, 1'b0);
    for (int k = 0; k < 4; k++) begin issue(k + 1, k, 16 * k, 1'b0); idle(1); end
    idle(16);

    // R5: eight-beat read cut after 2 clocks, then R4 chaining at 4 clocks, same bank
    setcfg(3, 0, 1'b1);
    issue(5, 2, 100, 1'b0); idle(1);
    issue(6, 2, 200, 1'b0); idle(3);
    issue(7, 5, 300, 1'b1); idle(16);

    // R2: minimum latency
    setcfg(2, 0, 1'b0);
    issue(8, 1, 40, 1'b0); idle(10);

    // random phases with legal gaps
    for (int p = 0; p < 20; p++) begin
      setcfg(2 + int'($urandom % 6), int'($urandom % 8), 1'($urandom));
      idle(1);
      for (int k = 0; k < 8; k++) begin
        bit ap = 1'($urandom);
        int gap;
        tag = (tag + 1) % 16;
        issue(tag, int'($urandom % 8), int'($urandom % 1024), ap);
        if (!cfg_bl8)                     gap = 2 + int'($urandom % 3);
        else if (!ap && ($urandom % 2))   gap = 2;
        else                              gap = 4 + int'($urandom % 2);
        idle(gap - 1);
      end
      idle(20);
    end

    // R8: no command, garbage fields and changing configuration
    idle_lbl = 8;
    for (int k = 0; k < 12; k++) begin
      setcfg(int'($urandom % 8), int'($urandom % 8), 1'($urandom));
      idle(1);
    end
    setcfg(3, 1, 1'b1);
    idle_lbl = 6;
    idle(4);

    // R1: reset drops a pending burst
    setcfg(7, 7, 1'b1);
    issue(9, 3, 77, 1'b0);
    idle(3);
    rst = 1'b1;
    for (int i = edge_n + 1; i < N; i++) ev[i] = 1'b0;
    idle_lbl = 1;
    step(); step();
    rst = 1'b0;
    idle(20);

    finish_run();
  end

endmodule